// File: doc/BRIEF.md
# Banked Register File Address Generator

This block forms the effective data-store address for the register-file operand of a small microcontroller core whose instructions are 14 bits wide. An instruction carries only a 7-bit file offset. The block widens that offset to a 9-bit address over four banks of 128 locations. In direct mode, two bank-select bits from the status register supply the upper address bits. When the instruction names offset 0, the access becomes indirect. The low eight address bits then come from an 8-bit pointer register, and a separate indirect-bank status bit supplies the ninth bit.

The block owns the three bank bits and the pointer register. Both are written through the ordinary file-write path, at their fixed offsets, and they are mirrored in every bank. The block also steers the operation result. Instruction bit 7 sends it either to the working register or back to the addressed file. The block also builds the operand read value, supplying its own registers where they are addressed and forcing zero for a null indirect access.

The path from the instruction to the address is purely combinational. Indirect and direct accesses therefore resolve in the same cycle.

Top module: `fsel_addr_gen`

## Requirements
- R1: When instruction bits 6:0 are nonzero (direct mode), eff_addr equals {RP1,RP0, instruction bits 6:0}, indirect_hit is 0, and the indirect-bank bit has no effect on eff_addr.
- R2: When instruction bits 6:0 are zero (indirect mode), indirect_hit is 1 and eff_addr equals {IRP, pointer[7:0]}, whatever the values of RP1:RP0.
- R3: A null access is an indirect access whose resulting address has bits 6:0 equal to zero. A null access raises null_hit, drives opnd_data to 00h and keeps file_we low, even when a file write is requested.
- R4: With res_valid high, instruction bit 7 = 0 raises w_we only and bit 7 = 1 raises file_we only (unless R3 applies). With res_valid low, neither enable rises. wdata carries res_data.
- R5: The pointer sits at offset 04h of every bank. A file write to that offset, direct or indirect, loads res_data into the pointer, and the new value is used from the next cycle. Reading that offset returns the pointer.
- R6: The status register sits at offset 03h of every bank. In it, bit 7 is IRP, bit 6 is RP1 and bit 5 is RP0. A file write there updates the bank bits from the next cycle. A read returns the block's bank bits in bits 7:5 and mem_rdata bits 4:0.
- R7: Synchronous reset clears IRP, RP1, RP0 and the pointer to zero.
- R8: The address, the mode flags and opnd_data follow the instruction in the same cycle in both modes, with no added wait cycle for indirect access.
- R9: A read of any other non-null offset passes mem_rdata to opnd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 14 | Instruction being executed; bits 6:0 file offset, bit 7 destination |
| res_valid | input | 1 | The instruction produces a result this cycle |
| res_data | input | 8 | Result value to be stored |
| mem_rdata | input | 8 | Data read from the store at eff_addr |
| eff_addr | output | 9 | Effective data-store address |
| indirect_hit | output | 1 | Access goes through the pointer |
| null_hit | output | 1 | Indirect access landed on offset 0 |
| opnd_data | output | 8 | Operand value seen by the datapath |
| file_we | output | 1 | Write enable toward the data store |
| w_we | output | 1 | Write enable toward the working register |
| wdata | output | 8 | Data for either write |

## Verification
A corrupted bank bit shows on eff_addr[8:7] of the very next direct access. A corrupted pointer or IRP bit shows on the next indirect access. The sweeps cover every offset in every bank and every pointer value under both IRP settings, so a stuck or crossed address bit reaches the ports within a few cycles. A wrong write-decode shows one cycle after the write, as an address that does not follow the written value. A wrong null decode shows at once as a stray file_we or as nonzero operand data.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    parameter int DW      = 8;   // data and pointer width
    parameter int OFS_W   = 7;   // file offset field width
    parameter int BANK_W  = 2;   // direct bank-select bits
    parameter int INSTR_W = 14;  // instruction word width

    localparam int AW        = BANK_W + OFS_W;   // effective address width
    localparam int XW        = AW - DW;          // indirect bank bits above pointer
    localparam int D_BIT     = OFS_W;            // destination select bit
    localparam int ST_RP_LO  = 5;                // bank-select field in status
    localparam int ST_IRP_LO = ST_RP_LO + BANK_W;

    localparam logic [OFS_W-1:0] OFS_INDF = '0;
    localparam logic [OFS_W-1:0] OFS_STAT = OFS_W'(3);
    localparam logic [OFS_W-1:0] OFS_PTR  = OFS_W'(4);

    typedef struct packed {
        logic [XW-1:0]     irp;
        logic [BANK_W-1:0] rp;
    } bank_t;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_STAT = 2'd1,
        SRC_PTR  = 2'd2,
        SRC_ZERO = 2'd3
    } rsrc_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          indirect;
        logic          null_acc;
        rsrc_e         src;
    } ea_t;

    function automatic rsrc_e classify(input logic [OFS_W-1:0] o);
        rsrc_e r;
        case (o)
            OFS_STAT: r = SRC_STAT;
            OFS_PTR:  r = SRC_PTR;
            default:  r = SRC_MEM;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] merge_status(input logic [DW-1:0] raw,
                                                   input bank_t b);
        logic [DW-1:0] v;
        v = raw;
        v[ST_RP_LO +: BANK_W] = b.rp;
        v[ST_IRP_LO +: XW]    = b.irp;
        return v;
    endfunction
endpackage

// File: rtl/fsel_bank_regs.sv
module fsel_bank_regs
    import fsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [DW-1:0]    wr_data,
    output bank_t            bank,
    output logic [DW-1:0]    ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
            ptr  <= '0;
        end else if (wr_en) begin
            if (wr_ofs == OFS_STAT) begin
                bank.irp <= wr_data[ST_IRP_LO +: XW];
                bank.rp  <= wr_data[ST_RP_LO +: BANK_W];
            end
            if (wr_ofs == OFS_PTR) begin
                ptr <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fsel_ea_gen.sv
module fsel_ea_gen
    import fsel_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  bank_t            bank,
    input  logic [DW-1:0]    ptr,
    output ea_t              ea
);
    logic          via_ptr;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] addr_i;

    assign via_ptr = (ofs == OFS_INDF);
    assign addr_d  = {bank.rp, ofs};

    generate
        if (XW > 0) begin : g_xbank
            assign addr_i = {bank.irp, ptr};
        end else begin : g_flat
            assign addr_i = ptr[AW-1:0];
        end
    endgenerate

    always_comb begin
        ea.indirect = via_ptr;
        ea.addr     = via_ptr ? addr_i : addr_d;
        ea.null_acc = via_ptr && (addr_i[OFS_W-1:0] == OFS_INDF);
        ea.src      = ea.null_acc ? SRC_ZERO : classify(ea.addr[OFS_W-1:0]);
    end
endmodule

// File: rtl/fsel_dest_steer.sv
module fsel_dest_steer
    import fsel_pkg::*;
(
    input  ea_t           ea,
    input  bank_t         bank,
    input  logic [DW-1:0] ptr,
    input  logic          res_valid,
    input  logic          dest_file,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] opnd_data,
    output logic          file_we,
    output logic          w_we
);
    always_comb begin
        unique case (ea.src)
            SRC_ZERO: opnd_data = '0;
            SRC_STAT: opnd_data = merge_status(mem_rdata, bank);
            SRC_PTR:  opnd_data = ptr;
            default:  opnd_data = mem_rdata;
        endcase
    end

    assign file_we = res_valid && dest_file && !ea.null_acc;
    assign w_we    = res_valid && !dest_file;
endmodule

// File: rtl/fsel_addr_gen.sv
module fsel_addr_gen
    import fsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               res_valid,
    input  logic [DW-1:0]      res_data,
    input  logic [DW-1:0]      mem_rdata,
    output logic [AW-1:0]      eff_addr,
    output logic               indirect_hit,
    output logic               null_hit,
    output logic [DW-1:0]      opnd_data,
    output logic               file_we,
    output logic               w_we,
    output logic [DW-1:0]      wdata
);
    bank_t         bank;
    logic [DW-1:0] ptr;
    ea_t           ea;
    logic          unused_hi;

    assign unused_hi = ^instr_word[INSTR_W-1:D_BIT+1];

    fsel_bank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (file_we),
        .wr_ofs  (ea.addr[OFS_W-1:0]),
        .wr_data (res_data),
        .bank    (bank),
        .ptr     (ptr)
    );

    fsel_ea_gen u_ea (
        .ofs  (instr_word[OFS_W-1:0]),
        .bank (bank),
        .ptr  (ptr),
        .ea   (ea)
    );

    fsel_dest_steer u_steer (
        .ea        (ea),
        .bank      (bank),
        .ptr       (ptr),
        .res_valid (res_valid),
        .dest_file (instr_word[D_BIT]),
        .mem_rdata (mem_rdata),
        .opnd_data (opnd_data),
        .file_we   (file_we),
        .w_we      (w_we)
    );

    assign eff_addr     = ea.addr;
    assign indirect_hit = ea.indirect;
    assign null_hit     = ea.null_acc;
    assign wdata        = res_data;
endmodule

// File: rtl/fsel_addr_gen_chk.sv
module fsel_addr_gen_chk
    import fsel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr_word,
    input logic               res_valid,
    input logic [DW-1:0]      res_data,
    input logic [AW-1:0]      eff_addr,
    input logic               indirect_hit,
    input logic               null_hit,
    input logic [DW-1:0]      opnd_data,
    input logic               file_we,
    input logic               w_we
);
    a_r2_mode_select: assert property (@(posedge clk) disable iff (rst)
        indirect_hit == (instr_word[OFS_W-1:0] == OFS_INDF));

    a_r3_null_blocks: assert property (@(posedge clk) disable iff (rst)
        null_hit |-> (!file_we && opnd_data == '0 && indirect_hit));

    a_r4_single_dest: assert property (@(posedge clk) disable iff (rst)
        $onehot0({file_we, w_we}));

    a_r4_file_dest: assert property (@(posedge clk) disable iff (rst)
        (res_valid && instr_word[D_BIT]) |-> (file_we || null_hit));

    a_r5_ptr_takes_effect: assert property (@(posedge clk) disable iff (rst)
        (file_we && eff_addr[OFS_W-1:0] == OFS_PTR) |=>
            (!indirect_hit || eff_addr[DW-1:0] == $past(res_data)));

    a_r6_bank_takes_effect: assert property (@(posedge clk) disable iff (rst)
        (file_we && eff_addr[OFS_W-1:0] == OFS_STAT) |=>
            (indirect_hit || eff_addr[AW-1:OFS_W] == $past(res_data[ST_RP_LO +: BANK_W])));

    a_r7_reset_bank: assert property (@(posedge clk)
        rst |=> (indirect_hit || eff_addr[AW-1:OFS_W] == '0));
endmodule

bind fsel_addr_gen fsel_addr_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_word   (instr_word),
    .res_valid    (res_valid),
    .res_data     (res_data),
    .eff_addr     (eff_addr),
    .indirect_hit (indirect_hit),
    .null_hit     (null_hit),
    .opnd_data    (opnd_data),
    .file_we      (file_we),
    .w_we         (w_we)
);

// File: tb/tb_fsel_addr_gen.sv
module tb_fsel_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] instr_word = '0;
    logic        res_valid = 1'b0;
    logic [7:0]  res_data = '0;
    logic [7:0]  mem_rdata = '0;
    logic [8:0]  eff_addr;
    logic        indirect_hit, null_hit, file_we, w_we;
    logic [7:0]  opnd_data, wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of owned state
    logic [2:0] m_bank = '0;   // {IRP, RP1, RP0}
    logic [7:0] m_ptr  = '0;

    always #4 clk = ~clk;

    fsel_addr_gen dut (
        .clk(clk), .rst(rst), .instr_word(instr_word), .res_valid(res_valid),
        .res_data(res_data), .mem_rdata(mem_rdata), .eff_addr(eff_addr),
        .indirect_hit(indirect_hit), .null_hit(null_hit), .opnd_data(opnd_data),
        .file_we(file_we), .w_we(w_we), .wdata(wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] iw(input logic d, input logic [6:0] o);
        return {6'b000111, d, o};
    endfunction

    // drive at negedge, commit on posedge
    task automatic file_write(input logic [6:0] o, input logic [7:0] v);
        logic [8:0] a;
        @(negedge clk);
        instr_word = iw(1'b1, o);
        res_valid  = 1'b1;
        res_data   = v;
        #1;
        a = (o == 0) ? {m_bank[2], m_ptr} : {m_bank[1:0], o};
        @(posedge clk);
        if (a[6:0] == 7'd3) m_bank = v[7:5];
        if (a[6:0] == 7'd4) m_ptr  = v;
        #1;
        res_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset state seen at the ports
        instr_word = iw(1'b0, 7'h25);
        #2;
        chk("R7 direct bank after reset", eff_addr, 9'h025);
        instr_word = iw(1'b0, 7'h00);
        #1;
        chk("R7 pointer after reset", eff_addr, 9'h000);
        chk("R7 null after reset", null_hit, 1);
        chk("R3 null operand", opnd_data, 0);

        // R1/R6/R5/R9/R8: every offset in every bank, IRP toggled to prove it is ignored
        for (int b = 0; b < 4; b++) begin
            logic [2:0] sb;
            sb = {b[0] ^ b[1], b[1:0]};
            file_write(7'd3, {sb, 5'b01010});
            for (int o = 1; o < 128; o++) begin
                logic [7:0] md, ex;
                @(negedge clk);
                instr_word = iw(1'b0, o[6:0]);
                md = o[7:0] ^ 8'h5A;
                mem_rdata = md;
                #2;
                chk("R1 direct address", eff_addr, b * 128 + o);
                chk("R1 direct mode flag", indirect_hit, 0);
                ex = (o == 3) ? {m_bank, md[4:0]} : (o == 4) ? m_ptr : md;
                chk(o == 3 ? "R6 status read" : o == 4 ? "R5 pointer read" : "R9 pass-through read",
                    opnd_data, ex);
            end
        end

        // R2/R3/R8: every pointer value under both IRP settings, RP set opposite
        for (int x = 0; x < 2; x++) begin
            file_write(7'd3, {x[0], ~x[0], 1'b1, 5'b0});
            for (int p = 0; p < 256; p++) begin
                file_write(7'd4, p[7:0]);
                @(negedge clk);
                instr_word = iw(1'b0, 7'h00);
                mem_rdata = 8'hC3;
                #2;
                chk("R2 indirect address", eff_addr, x * 256 + p);
                chk("R2 indirect flag", indirect_hit, 1);
                chk("R3 null detect", null_hit, (p % 128) == 0);
                if ((p % 128) == 0) chk("R3 null operand zero", opnd_data, 0);
            end
        end

        // R3: write through a null indirect access is dropped
        file_write(7'd3, 8'h00);
        file_write(7'd4, 8'h00);
        @(negedge clk);
        instr_word = iw(1'b1, 7'h00); res_valid = 1'b1; res_data = 8'hAA;
        #2;
        chk("R3 null write blocked", file_we, 0);
        res_valid = 1'b0;

        // R4: destination select
        @(negedge clk);
        instr_word = iw(1'b0, 7'h30); res_valid = 1'b1; res_data = 8'h77;
        #2;
        chk("R4 d=0 w_we", w_we, 1);
        chk("R4 d=0 file_we", file_we, 0);
        chk("R4 wdata", wdata, 8'h77);
        instr_word = iw(1'b1, 7'h30);
        #1;
        chk("R4 d=1 file_we", file_we, 1);
        chk("R4 d=1 w_we", w_we, 0);
        res_valid = 1'b0;
        #1;
        chk("R4 idle enables", {file_we, w_we}, 0);

        // R5: indirect write onto the pointer's own offset reloads it
        file_write(7'd4, 8'h84);
        file_write(7'd0, 8'h55);
        @(negedge clk);
        instr_word = iw(1'b0, 7'h00);
        #2;
        chk("R5 pointer self-reload", eff_addr, 9'h055);
        chk("R5 indirect write enable seen earlier", m_ptr, 8'h55);

        // R6: status written through a high bank mirror
        file_write(7'd3, 8'h40);
        file_write(7'd3, 8'hE0);
        @(negedge clk);
        instr_word = iw(1'b0, 7'h11);
        #2;
        chk("R6 bank via mirror", eff_addr, 9'h191);

        // R7: mid-run reset clears bank bits and pointer
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_bank = '0; m_ptr = '0;
        instr_word = iw(1'b0, 7'h11);
        #2;
        chk("R7 bank cleared", eff_addr, 9'h011);
        instr_word = iw(1'b0, 7'h00);
        #1;
        chk("R7 pointer cleared", eff_addr, 9'h000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule